// File: doc/BRIEF.md
# Host Command and Reply Queue Register Port

This block is the device-side register front end of a storage controller. A host hands command addresses to the controller through two 16-entry queues, using a simple 32-bit register bus with word offsets. A host write to the submit register pushes a 32-bit command list bus address into a request queue, which the controller core drains through a valid/ready handshake. The core pushes the addresses of finished commands into a reply queue, and the host reads and retires them through a completion register.

Reading the completion register shows the oldest reply without removing it; an empty queue reads as all ones. The host retires the shown entry by writing zero to the same register. Reading the submit register returns a room flag rather than queue data. The interrupt enable has inverted sense: writing zero enables the reply interrupt and writing bit 3 masks it. A status register reports a pending bit that is set while replies are waiting, and a sticky overflow bit.

The bus front end is a two-state machine. In `BS_IDLE` no read response is shown. A read strobe moves it to `BS_RESP` (transition IDLE-to-RESP). In `BS_RESP`, which drives the read-valid flag, a new read strobe keeps it there (RESP-to-RESP, back-to-back read). With no read strobe it returns to `BS_IDLE` (RESP-to-IDLE). Writes complete in one cycle in either state and do not change the state.

Top module: `hostq_port`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) empties both queues and masks the interrupt. After reset `irq` is 0, the mask register reads 8, the submit register reads 1, and the completion register reads 0xFFFFFFFF.
- R2: A bus write to offset 0 (submit) while the request queue is not full pushes `bus_wdata`. The core sees the entries on `core_req_addr`/`core_req_valid` in write order, and each cycle with `core_req_ready` high while valid removes one entry.
- R3: A bus read of offset 0 returns 1 while the request queue has a free entry and 0 when it holds 16 entries.
- R4: A submit write while the request queue is full is dropped and sets a sticky overflow flag, bit 1 of the status register at offset 3. Only reset clears the flag.
- R5: A bus read of offset 1 (completion) while the reply queue is empty returns 0xFFFFFFFF.
- R6: A bus read of offset 1 while the reply queue is not empty returns the oldest reply and leaves it in the queue.
- R7: A bus write of 0 to offset 1 removes the oldest reply. A write of any nonzero value to offset 1 has no effect, and a zero write while the reply queue is empty has no effect.
- R8: A write to offset 2 (mask) loads bit 3 of the written value as the interrupt mask: 0 enables the interrupt and 8 masks it. A read of offset 2 returns the mask at bit 3 and zeros elsewhere.
- R9: Bit 0 of the status register at offset 3 is 1 exactly while the reply queue is not empty. Writes to offset 3 have no effect.
- R10: `irq` is 1 exactly when the reply queue is not empty and the mask is 0.
- R11: `core_rpl_ready` is 0 while the reply queue holds 16 entries, and a core push in that state is dropped. Otherwise a cycle with `core_rpl_valid` high pushes `core_rpl_addr`.
- R12: Bus reads have one cycle of latency. `bus_rvalid` is 1 in the cycle after a cycle with `bus_rd` high and 0 otherwise. `bus_rdata` then holds the value selected by the state at the strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response flag, one cycle after bus_rd |
| core_req_valid | output | 1 | Request queue holds an entry |
| core_req_ready | input | 1 | Core takes the head request |
| core_req_addr | output | 32 | Head request command address |
| core_rpl_valid | input | 1 | Core offers a completed command address |
| core_rpl_ready | output | 1 | Reply queue has room |
| core_rpl_addr | input | 32 | Completed command address from the core |
| irq | output | 1 | Reply interrupt |

## Verification
The assertions assume the host never raises `bus_wr` and `bus_rd` in the same cycle. The properties that count queue entries across a host access also assume the core side is quiet in that cycle: no core pop during a checked submit, and no core push during a checked completion write. The directed stimulus drives one host strobe at a time on the falling edge. It keeps the core handshakes in cycles of their own, so every access matches those conditions and each property meets its precondition.

// File: rtl/hostq_pkg.sv
package hostq_pkg;

    localparam int BUS_ADDR_W = 3;
    localparam int BUS_DATA_W = 32;

    // Register word offsets
    localparam logic [BUS_ADDR_W-1:0] OFS_SUBMIT   = 3'd0;
    localparam logic [BUS_ADDR_W-1:0] OFS_COMPLETE = 3'd1;
    localparam logic [BUS_ADDR_W-1:0] OFS_MASK     = 3'd2;
    localparam logic [BUS_ADDR_W-1:0] OFS_STATUS   = 3'd3;

    // Bit of the mask register that holds the interrupt mask
    localparam int MASK_BIT = 3;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = store[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hostq_regs.sv
module hostq_regs
    import hostq_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              req_full,
    input  logic              rpl_empty,
    input  logic [DATA_W-1:0] rpl_head,
    output logic              req_push,
    output logic              rpl_pop,
    output logic              mask_q,
    output logic              ovf_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);

    bus_state_e state_q;
    bus_state_e state_d;

    logic wr_submit;
    logic wr_complete;
    logic wr_mask;

    always_comb begin
        wr_submit   = bus_wr && (bus_addr == ADDR_W'(OFS_SUBMIT));
        wr_complete = bus_wr && (bus_addr == ADDR_W'(OFS_COMPLETE));
        wr_mask     = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
        req_push    = wr_submit;
        rpl_pop     = wr_complete && (bus_wdata == '0);
    end

    // Next-state logic of the read-response machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: state_d = bus_rd ? BS_RESP : BS_IDLE;
            BS_RESP: state_d = bus_rd ? BS_RESP : BS_IDLE;
            default: state_d = BS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs of the machine
    always_comb begin
        bus_rvalid = (state_q == BS_RESP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(OFS_SUBMIT):   bus_rdata <= {{(DATA_W-1){1'b0}}, !req_full};
                ADDR_W'(OFS_COMPLETE): bus_rdata <= rpl_empty ? '1 : rpl_head;
                ADDR_W'(OFS_MASK):     bus_rdata <= DATA_W'(mask_q) << MASK_BIT;
                ADDR_W'(OFS_STATUS):   bus_rdata <= {{(DATA_W-2){1'b0}}, ovf_q, !rpl_empty};
                default:               bus_rdata <= '0;
            endcase
        end
    end

    // Mask and sticky overflow
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b1;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_mask) begin
                mask_q <= bus_wdata[MASK_BIT];
            end
            if (wr_submit && req_full) begin
                ovf_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hostq_port.sv
module hostq_port
    import hostq_pkg::*;
#(
    parameter int ADDR_W    = BUS_ADDR_W,
    parameter int DATA_W    = BUS_DATA_W,
    parameter int REQ_DEPTH = 16,
    parameter int RPL_DEPTH = 16,
    localparam int REQ_CNT_W = $clog2(REQ_DEPTH + 1),
    localparam int RPL_CNT_W = $clog2(RPL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              core_req_valid,
    input  logic              core_req_ready,
    output logic [DATA_W-1:0] core_req_addr,
    input  logic              core_rpl_valid,
    output logic              core_rpl_ready,
    input  logic [DATA_W-1:0] core_rpl_addr,
    output logic              irq
);

    logic                 req_push;
    logic                 req_empty;
    logic                 req_full;
    logic [REQ_CNT_W-1:0] req_count;
    logic                 rpl_pop;
    logic                 rpl_empty;
    logic                 rpl_full;
    logic [RPL_CNT_W-1:0] rpl_count;
    logic [DATA_W-1:0]    rpl_head;
    logic                 mask_q;
    logic                 ovf_q;

    hostq_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .req_full   (req_full),
        .rpl_empty  (rpl_empty),
        .rpl_head   (rpl_head),
        .req_push   (req_push),
        .rpl_pop    (rpl_pop),
        .mask_q     (mask_q),
        .ovf_q      (ovf_q),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    hostq_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (REQ_DEPTH)
    ) u_req_q (
        .clk       (clk),
        .rst       (rst),
        .push      (req_push),
        .push_data (bus_wdata),
        .pop       (core_req_ready),
        .head      (core_req_addr),
        .empty     (req_empty),
        .full      (req_full),
        .count     (req_count)
    );

    hostq_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (RPL_DEPTH)
    ) u_rpl_q (
        .clk       (clk),
        .rst       (rst),
        .push      (core_rpl_valid),
        .push_data (core_rpl_addr),
        .pop       (rpl_pop),
        .head      (rpl_head),
        .empty     (rpl_empty),
        .full      (rpl_full),
        .count     (rpl_count)
    );

    always_comb begin
        core_req_valid = !req_empty;
        core_rpl_ready = !rpl_full;
        irq            = !rpl_empty && !mask_q;
    end

endmodule

// File: rtl/hostq_port_chk.sv
module hostq_port_chk
    import hostq_pkg::*;
#(
    parameter int ADDR_W    = BUS_ADDR_W,
    parameter int DATA_W    = BUS_DATA_W,
    parameter int REQ_DEPTH = 16,
    parameter int RPL_DEPTH = 16,
    localparam int REQ_CNT_W = $clog2(REQ_DEPTH + 1),
    localparam int RPL_CNT_W = $clog2(RPL_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 bus_rvalid,
    input logic                 core_req_ready,
    input logic                 core_rpl_valid,
    input logic                 core_rpl_ready,
    input logic                 irq,
    input logic                 req_full,
    input logic [REQ_CNT_W-1:0] req_count,
    input logic                 rpl_empty,
    input logic [RPL_CNT_W-1:0] rpl_count,
    input logic [DATA_W-1:0]    rpl_head,
    input logic                 mask_q,
    input logic                 ovf_q
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q && !ovf_q && req_count == '0 && rpl_count == '0));

    a_r2_submit_push: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_SUBMIT) && !req_full && !core_req_ready)
        |=> (req_count == $past(req_count) + 1'b1));

    a_r3_room_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_SUBMIT))
        |=> (bus_rdata == ($past(req_full) ? DATA_W'(0) : DATA_W'(1))));

    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_SUBMIT) && req_full && !core_req_ready)
        |=> (ovf_q && req_count == $past(req_count)));

    a_r4_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    a_r5_empty_reads_ones: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_COMPLETE) && rpl_empty)
        |=> (bus_rdata == '1));

    a_r6_peek_head: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_COMPLETE) && !rpl_empty && !core_rpl_valid)
        |=> (bus_rdata == $past(rpl_head) && rpl_count == $past(rpl_count)));

    a_r7_nonzero_no_pop: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_COMPLETE) && bus_wdata != '0 && !core_rpl_valid)
        |=> (rpl_count == $past(rpl_count)));

    a_r7_zero_pops: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_COMPLETE) && bus_wdata == '0 && !rpl_empty
         && !core_rpl_valid)
        |=> (rpl_count == $past(rpl_count) - 1'b1));

    a_r8_mask_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> (mask_q == $past(bus_wdata[MASK_BIT])));

    a_r9_pending_bit: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_STATUS))
        |=> (bus_rdata[0] == (($past(rpl_count)) != '0)));

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        mask_q |-> !irq);

    a_r10_unmasked_fires: assert property (@(posedge clk) disable iff (rst)
        (!mask_q && rpl_count != '0) |-> irq);

    a_r11_full_not_ready: assert property (@(posedge clk) disable iff (rst)
        (rpl_count == RPL_CNT_W'(RPL_DEPTH)) |-> !core_rpl_ready);

    a_r12_read_latency: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

endmodule

bind hostq_port hostq_port_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REQ_DEPTH (REQ_DEPTH),
    .RPL_DEPTH (RPL_DEPTH)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .bus_rvalid     (bus_rvalid),
    .core_req_ready (core_req_ready),
    .core_rpl_valid (core_rpl_valid),
    .core_rpl_ready (core_rpl_ready),
    .irq            (irq),
    .req_full       (req_full),
    .req_count      (req_count),
    .rpl_empty      (rpl_empty),
    .rpl_count      (rpl_count),
    .rpl_head       (rpl_head),
    .mask_q         (mask_q),
    .ovf_q          (ovf_q)
);

// File: tb/test_hostq_port.sv
module test_hostq_port;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        core_req_valid;
    logic        core_req_ready = 1'b0;
    logic [31:0] core_req_addr;
    logic        core_rpl_valid = 1'b0;
    logic        core_rpl_ready;
    logic [31:0] core_rpl_addr = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hostq_port i_hostq_port (
        .clk            (clk),
        .rst            (rst),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .bus_rvalid     (bus_rvalid),
        .core_req_valid (core_req_valid),
        .core_req_ready (core_req_ready),
        .core_req_addr  (core_req_addr),
        .core_rpl_valid (core_rpl_valid),
        .core_rpl_ready (core_rpl_ready),
        .core_rpl_addr  (core_rpl_addr),
        .irq            (irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Returns read data sampled in the response cycle
    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic core_push(input logic [31:0] d);
        @(negedge clk);
        core_rpl_valid = 1'b1; core_rpl_addr = d;
        @(negedge clk);
        core_rpl_valid = 1'b0;
    endtask

    task automatic core_pop();
        @(negedge clk);
        core_req_ready = 1'b1;
        @(negedge clk);
        core_req_ready = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        do_reset();
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
        check(core_req_valid == 1'b0, "R1 request queue empty", 32'(core_req_valid), 0);
        bus_read(3'd2, d, v);
        check(d == 32'h8, "R1 mask reads 8", d, 32'h8);
        check(v == 1'b1, "R12 rvalid after read", 32'(v), 1);
        bus_read(3'd0, d, v);
        check(d == 32'h1, "R1 submit room", d, 32'h1);
        bus_read(3'd1, d, v);
        check(d == 32'hFFFF_FFFF, "R1 completion empty", d, 32'hFFFF_FFFF);
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R12 rvalid drops", 32'(bus_rvalid), 0);
    endtask

    task automatic t_submit_drain();
        logic [31:0] d; logic v;
        do_reset();
        for (int i = 0; i < 3; i++) bus_write(3'd0, 32'h1000_0000 + 32'(i * 32));
        check(core_req_valid == 1'b1, "R2 valid after submit", 32'(core_req_valid), 1);
        bus_read(3'd0, d, v);
        check(d == 32'h1, "R3 room while partly filled", d, 32'h1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(core_req_addr == 32'h1000_0000 + 32'(i * 32), "R2 drain order",
                  core_req_addr, 32'h1000_0000 + 32'(i * 32));
            core_pop();
        end
        check(core_req_valid == 1'b0, "R2 drained empty", 32'(core_req_valid), 0);
    endtask

    task automatic t_request_full();
        logic [31:0] d; logic v;
        do_reset();
        for (int i = 0; i < DEPTH; i++) bus_write(3'd0, 32'hA000_0000 + 32'(i));
        bus_read(3'd0, d, v);
        check(d == 32'h0, "R3 full reads zero", d, 32'h0);
        bus_read(3'd3, d, v);
        check(d == 32'h0, "R4 no overflow yet", d, 32'h0);
        bus_write(3'd0, 32'hDEAD_BEEF);
        bus_read(3'd3, d, v);
        check(d == 32'h2, "R4 overflow flag set", d, 32'h2);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            check(core_req_valid && core_req_addr == 32'hA000_0000 + 32'(i),
                  "R4 entries intact", core_req_addr, 32'hA000_0000 + 32'(i));
            core_pop();
        end
        check(core_req_valid == 1'b0, "R4 dropped write absent", 32'(core_req_valid), 0);
        bus_read(3'd3, d, v);
        check(d == 32'h2, "R4 overflow sticky", d, 32'h2);
    endtask

    task automatic t_reply_peek_pop();
        logic [31:0] d; logic v;
        do_reset();
        core_push(32'h0000_1230);
        core_push(32'h0000_4560);
        bus_read(3'd1, d, v);
        check(d == 32'h0000_1230, "R6 peek head", d, 32'h0000_1230);
        bus_read(3'd1, d, v);
        check(d == 32'h0000_1230, "R6 peek not removed", d, 32'h0000_1230);
        bus_write(3'd1, 32'h5);
        bus_read(3'd1, d, v);
        check(d == 32'h0000_1230, "R7 nonzero write ignored", d, 32'h0000_1230);
        bus_write(3'd1, 32'h0);
        bus_read(3'd1, d, v);
        check(d == 32'h0000_4560, "R7 zero write pops", d, 32'h0000_4560);
        bus_write(3'd1, 32'h0);
        bus_read(3'd1, d, v);
        check(d == 32'hFFFF_FFFF, "R5 empty after pops", d, 32'hFFFF_FFFF);
        bus_write(3'd1, 32'h0);
        core_push(32'h0000_7890);
        bus_read(3'd1, d, v);
        check(d == 32'h0000_7890, "R7 pop on empty ignored", d, 32'h0000_7890);
    endtask

    task automatic t_irq();
        logic [31:0] d; logic v;
        do_reset();
        core_push(32'h0000_00C0);
        check(irq == 1'b0, "R10 masked no irq", 32'(irq), 0);
        bus_read(3'd3, d, v);
        check(d == 32'h1, "R9 pending set", d, 32'h1);
        bus_write(3'd3, 32'h0);
        bus_read(3'd3, d, v);
        check(d == 32'h1, "R9 status write ignored", d, 32'h1);
        bus_write(3'd2, 32'h0);
        check(irq == 1'b1, "R10 unmasked irq", 32'(irq), 1);
        bus_read(3'd2, d, v);
        check(d == 32'h0, "R8 mask reads 0", d, 32'h0);
        bus_write(3'd2, 32'h8);
        check(irq == 1'b0, "R8 bit3 masks", 32'(irq), 0);
        bus_write(3'd2, 32'hFFFF_FFF7);
        check(irq == 1'b1, "R8 only bit3 matters", 32'(irq), 1);
        bus_write(3'd1, 32'h0);
        check(irq == 1'b0, "R10 irq clears when empty", 32'(irq), 0);
        bus_read(3'd3, d, v);
        check(d == 32'h0, "R9 pending clear", d, 32'h0);
    endtask

    task automatic t_reply_full();
        logic [31:0] d; logic v;
        do_reset();
        for (int i = 0; i < DEPTH; i++) core_push(32'hB000_0000 + 32'(i));
        check(core_rpl_ready == 1'b0, "R11 not ready when full", 32'(core_rpl_ready), 0);
        core_push(32'hCAFE_0000);
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(3'd1, d, v);
            check(d == 32'hB000_0000 + 32'(i), "R11 reply order", d, 32'hB000_0000 + 32'(i));
            bus_write(3'd1, 32'h0);
        end
        bus_read(3'd1, d, v);
        check(d == 32'hFFFF_FFFF, "R11 dropped push absent", d, 32'hFFFF_FFFF);
        check(core_rpl_ready == 1'b1, "R11 ready again", 32'(core_rpl_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_submit_drain();
        t_request_full();
        t_reply_peek_pop();
        t_irq();
        t_reply_full();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule